// File: doc/BRIEF.md
# Breakpoint Address Match Unit

This block watches the instruction stream and its memory and port accesses against a small set of breakpoint slots. Each slot carries an enable bit, a two-bit kind code and a base address. A fetch-kind slot is checked against the address of each instruction as it starts. When it matches, the block raises a fault-class request before that instruction runs. The remaining kinds are checked against the accesses the instruction makes. Their matches are held back and raised as a trap-class request only once the instruction, or the current iteration of a repeated string instruction, has finished.

A one-shot resume flag lets an exception handler return to a faulting instruction without hitting the same fetch breakpoint again. The flag masks fetch matches for exactly one instruction and then clears. It has no effect on access matches. A hit vector shows which slots caused the request raised in the same cycle.

Top module: `bkpt_match_unit`

## Requirements
- R1: Reset drives `fault_req`, `trap_req` and `hit_vec` to zero and clears the resume flag, so the first fetch match after reset raises a fault.
- R2: When `insn_start` is high and `insn_addr` equals the base of an enabled fetch-kind slot (kind 0), `fault_req` is high in the next cycle. Bit i of `hit_vec` is set for each such slot i.
- R3: A slot whose bit in `slot_en` is clear never matches, whatever its kind and base.
- R4: The kind codes are: 0 matches fetches only, 1 matches memory writes only (`mem_write`=1), 2 matches port accesses (`io_valid`) only, and 3 matches memory reads and writes. No kind matches the other sources.
- R5: A memory or port match never raises a request during the instruction. `trap_req` rises in the cycle after `insn_done` for the instruction that made the access, including an access in the same cycle as `insn_done`.
- R6: `resume_set` sets the resume flag. While the flag is set, a starting instruction raises no fetch fault. `insn_done` clears the flag, but a `resume_set` in the same cycle keeps it set.
- R7: The resume flag never masks a memory or port match.
- R8: Every slot that matches within one request sets its own bit in `hit_vec`.
- R9: While `str_rep` is high, each `str_iter_done` ends an iteration. Matches collected since the last boundary then raise `trap_req` in the next cycle and are cleared. For a repeated port string operation, a port match therefore traps after the first iteration.
- R10: `str_iter_done` has no effect while `str_rep` is low.
- R11: `hit_vec` is zero in any cycle with neither request. When a fault and a trap are raised in the same cycle, it holds the union of both slot sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_en | input | NUM_SLOTS | Per-slot enable |
| slot_kind | input | 2*NUM_SLOTS | Per-slot kind code, slot i in bits [2i+1:2i] |
| slot_base | input | NUM_SLOTS*ADDR_W | Per-slot base address, slot i in bits [ADDR_W*i +: ADDR_W] |
| insn_start | input | 1 | An instruction begins at `insn_addr` |
| insn_addr | input | ADDR_W | Fetch address of the starting instruction |
| insn_done | input | 1 | The current instruction has completed |
| resume_set | input | 1 | Sets the one-shot resume flag |
| mem_valid | input | 1 | Memory access strobe |
| mem_addr | input | ADDR_W | Memory access address |
| mem_write | input | 1 | Memory access is a write |
| io_valid | input | 1 | Port access strobe |
| io_addr | input | ADDR_W | Port access address |
| str_rep | input | 1 | Current instruction is a repeated string operation |
| str_iter_done | input | 1 | One string iteration has completed |
| fault_req | output | 1 | Fault-class request from a fetch match |
| trap_req | output | 1 | Trap-class request from memory or port matches |
| hit_vec | output | NUM_SLOTS | Slots behind the request raised in the same cycle |

## Verification
The hardest situations to reach are the ones where events overlap in time. One is a `resume_set` that arrives in the same cycle as the `insn_done` that would clear the flag. Another is a string iteration boundary that falls in the same cycle as the matching access. A third is an instruction finishing with a pending trap in the same cycle as the next instruction's fetch match. The stimulus builds each of these by driving the coinciding strobes together in one cycle. This comes after a sweep over every kind assignment, a spread of enable patterns and a band of addresses, which includes two slots sharing one base.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    BK_FETCH = 2'd0,
    BK_WRITE = 2'd1,
    BK_PORT  = 2'd2,
    BK_RDWR  = 2'd3
  } bk_kind_e;

  typedef enum logic [1:0] {
    SRC_FETCH = 2'd0,
    SRC_MEM   = 2'd1,
    SRC_PORT  = 2'd2
  } bk_src_e;

  // Does a slot of kind k react to an event from source s (wr: memory write)?
  function automatic logic kind_sees(input bk_kind_e k, input bk_src_e s, input logic wr);
    logic r;
    case (s)
      SRC_FETCH: r = (k == BK_FETCH);
      SRC_MEM:   r = (k == BK_RDWR) || ((k == BK_WRITE) && wr);
      SRC_PORT:  r = (k == BK_PORT);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bkpt_slot.sv
module bkpt_slot
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              en,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] base,
  input  logic              insn_start,
  input  logic [ADDR_W-1:0] insn_addr,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_write,
  input  logic              io_valid,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              fetch_hit,
  output logic              access_hit
);

  bk_kind_e k;
  logic     mem_hit;
  logic     port_hit;

  assign k = bk_kind_e'(kind);

  always_comb begin
    fetch_hit = en && insn_start && kind_sees(k, SRC_FETCH, 1'b0) && (insn_addr == base);
    mem_hit   = mem_valid && kind_sees(k, SRC_MEM, mem_write) && (mem_addr == base);
    port_hit  = io_valid && kind_sees(k, SRC_PORT, 1'b0) && (io_addr == base);
    access_hit = en && (mem_hit || port_hit);
  end

endmodule

// File: rtl/bkpt_resume.sv
module bkpt_resume (
  input  logic clk,
  input  logic rst_n,
  input  logic resume_set,
  input  logic insn_done,
  output logic resume_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          resume_q <= 1'b0;
    else if (resume_set) resume_q <= 1'b1;
    else if (insn_done)  resume_q <= 1'b0;
  end

endmodule

// File: rtl/bkpt_trap_accum.sv
module bkpt_trap_accum #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] access_hit,
  input  logic                 insn_done,
  input  logic                 str_rep,
  input  logic                 str_iter_done,
  output logic                 flush_evt,
  output logic [NUM_SLOTS-1:0] flush_bits
);

  logic [NUM_SLOTS-1:0] pend_q;
  logic [NUM_SLOTS-1:0] merged;

  always_comb begin
    merged     = pend_q | access_hit;
    flush_evt  = insn_done || (str_rep && str_iter_done);
    flush_bits = flush_evt ? merged : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= '0;
    else if (flush_evt) pend_q <= '0;
    else                pend_q <= merged;
  end

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        slot_en,
  input  logic [2*NUM_SLOTS-1:0]      slot_kind,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_base,
  input  logic                        insn_start,
  input  logic [ADDR_W-1:0]           insn_addr,
  input  logic                        insn_done,
  input  logic                        resume_set,
  input  logic                        mem_valid,
  input  logic [ADDR_W-1:0]           mem_addr,
  input  logic                        mem_write,
  input  logic                        io_valid,
  input  logic [ADDR_W-1:0]           io_addr,
  input  logic                        str_rep,
  input  logic                        str_iter_done,
  output logic                        fault_req,
  output logic                        trap_req,
  output logic [NUM_SLOTS-1:0]        hit_vec
);

  localparam int KW = 2;

  logic [NUM_SLOTS-1:0] fetch_raw;
  logic [NUM_SLOTS-1:0] fetch_ok;
  logic [NUM_SLOTS-1:0] access_raw;
  logic [NUM_SLOTS-1:0] flush_bits;
  logic                 flush_evt;
  logic                 resume_q;
  logic                 fault_fire;
  logic                 trap_fire;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    bkpt_slot #(.ADDR_W(ADDR_W)) u_slot (
      .en         (slot_en[i]),
      .kind       (slot_kind[KW*i +: KW]),
      .base       (slot_base[ADDR_W*i +: ADDR_W]),
      .insn_start (insn_start),
      .insn_addr  (insn_addr),
      .mem_valid  (mem_valid),
      .mem_addr   (mem_addr),
      .mem_write  (mem_write),
      .io_valid   (io_valid),
      .io_addr    (io_addr),
      .fetch_hit  (fetch_raw[i]),
      .access_hit (access_raw[i])
    );
  end

  bkpt_resume u_resume (
    .clk        (clk),
    .rst_n      (rst_n),
    .resume_set (resume_set),
    .insn_done  (insn_done),
    .resume_q   (resume_q)
  );

  bkpt_trap_accum #(.NUM_SLOTS(NUM_SLOTS)) u_accum (
    .clk           (clk),
    .rst_n         (rst_n),
    .access_hit    (access_raw),
    .insn_done     (insn_done),
    .str_rep       (str_rep),
    .str_iter_done (str_iter_done),
    .flush_evt     (flush_evt),
    .flush_bits    (flush_bits)
  );

  always_comb begin
    fetch_ok   = resume_q ? '0 : fetch_raw;
    fault_fire = |fetch_ok;
    trap_fire  = |flush_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_req <= 1'b0;
      trap_req  <= 1'b0;
      hit_vec   <= '0;
    end else begin
      fault_req <= fault_fire;
      trap_req  <= trap_fire;
      hit_vec   <= fetch_ok | flush_bits;
    end
  end

endmodule

// File: rtl/bkpt_match_unit_chk.sv
module bkpt_match_unit_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 insn_start,
  input logic                 insn_done,
  input logic                 resume_set,
  input logic                 str_rep,
  input logic                 str_iter_done,
  input logic [NUM_SLOTS-1:0] slot_en,
  input logic                 fault_req,
  input logic                 trap_req,
  input logic [NUM_SLOTS-1:0] hit_vec,
  input logic                 resume_q,
  input logic [NUM_SLOTS-1:0] fetch_raw,
  input logic                 flush_evt,
  input logic [NUM_SLOTS-1:0] flush_bits
);

  AST_FETCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fetch_raw) && !resume_q) |=> fault_req); // R2

  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> $past(insn_start)); // R2

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req && !trap_req) |-> ((hit_vec & ~$past(slot_en)) == '0)); // R3

  AST_TRAP_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(insn_done || (str_rep && str_iter_done))); // R5

  AST_RESUME_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_q && insn_start) |=> !fault_req); // R6

  AST_RESUME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !resume_set) |=> !resume_q); // R6

  AST_RESUME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resume_set |=> resume_q); // R6

  AST_REQ_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req || trap_req) |-> (hit_vec != '0)); // R8

  AST_FLUSH_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_evt && (|flush_bits)) |=> trap_req); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_req && !trap_req) |-> (hit_vec == '0)); // R11

endmodule

bind bkpt_match_unit bkpt_match_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_start    (insn_start),
  .insn_done     (insn_done),
  .resume_set    (resume_set),
  .str_rep       (str_rep),
  .str_iter_done (str_iter_done),
  .slot_en       (slot_en),
  .fault_req     (fault_req),
  .trap_req      (trap_req),
  .hit_vec       (hit_vec),
  .resume_q      (resume_q),
  .fetch_raw     (fetch_raw),
  .flush_evt     (flush_evt),
  .flush_bits    (flush_bits)
);

// File: tb/bkpt_match_unit_bench.sv
module bkpt_match_unit_bench;

  localparam int N = 4;
  localparam int A = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   slot_en = '0;
  logic [2*N-1:0] slot_kind = '0;
  logic [N*A-1:0] slot_base = '0;
  logic           insn_start = 0, insn_done = 0, resume_set = 0;
  logic [A-1:0]   insn_addr = '0, mem_addr = '0, io_addr = '0;
  logic           mem_valid = 0, mem_write = 0, io_valid = 0;
  logic           str_rep = 0, str_iter_done = 0;
  logic           fault_req, trap_req;
  logic [N-1:0]   hit_vec;

  int n_tests = 0;
  int n_fail  = 0;
  int base_of [N] = '{3, 7, 7, 12};

  always #5 clk = ~clk;

  bkpt_match_unit #(.NUM_SLOTS(N), .ADDR_W(A)) u_bkpt_match_unit (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_kind(slot_kind), .slot_base(slot_base),
    .insn_start(insn_start), .insn_addr(insn_addr), .insn_done(insn_done), .resume_set(resume_set),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_write(mem_write),
    .io_valid(io_valid), .io_addr(io_addr), .str_rep(str_rep), .str_iter_done(str_iter_done),
    .fault_req(fault_req), .trap_req(trap_req), .hit_vec(hit_vec)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    insn_start = 0; insn_done = 0; resume_set = 0; mem_valid = 0; mem_write = 0;
    io_valid = 0; str_iter_done = 0;
  endtask

  task automatic set_bases(input int b0, input int b1, input int b2, input int b3);
    slot_base = {A'(b3), A'(b2), A'(b1), A'(b0)};
  endtask

  // Expected slot sets from the kind codes: 0 fetch, 1 write, 2 port, 3 read/write
  function automatic logic [N-1:0] exp_fetch(input int a);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      r[i] = slot_en[i] && (slot_kind[2*i +: 2] == 2'd0) && (base_of[i] == a);
    return r;
  endfunction

  function automatic logic [N-1:0] exp_access(input int ma, input logic wr, input int pa);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      int k = int'(slot_kind[2*i +: 2]);
      r[i] = slot_en[i] && (((k == 3 || (k == 1 && wr)) && base_of[i] == ma) ||
                            (k == 2 && base_of[i] == pa));
    end
    return r;
  endfunction

  task automatic sweep_insn(input int a);
    logic [N-1:0] ef, ea;
    ef = exp_fetch(a);
    ea = exp_access(a, a[0], a ^ 1);
    insn_start = 1; insn_addr = A'(a);
    tick();
    check("R2/R3/R4 fetch fault", fault_req, |ef);
    check("R8/R11 fetch hit_vec", hit_vec, ef);
    insn_start = 0; mem_valid = 1; mem_addr = A'(a); mem_write = a[0];
    tick();
    check("R5 no trap mid-instruction", trap_req, 0);
    mem_valid = 0; io_valid = 1; io_addr = A'(a ^ 1); insn_done = 1;
    tick();
    check("R4/R5 access trap", trap_req, |ea);
    check("R8/R11 trap hit_vec", hit_vec, ea);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    set_bases(3, 7, 7, 12);
    repeat (3) tick();
    check("R1 reset fault_req", fault_req, 0);
    check("R1 reset trap_req", trap_req, 0);
    check("R1 reset hit_vec", hit_vec, 0);
    rst_n = 1;
    tick();

    // Sweep every kind assignment with a varying enable pattern
    for (int cfg = 0; cfg < 256; cfg++) begin
      slot_kind = 8'(cfg);
      slot_en   = 4'(cfg) ^ 4'(cfg >> 4) ^ 4'b1010;
      for (int a = 0; a < 16; a++) sweep_insn(a);
    end

    // Resume flag: slot0 fetch 0x20, slot1 read/write 0x40
    base_of = '{32'h20, 32'h40, 32'h9, 32'h77};
    set_bases(32'h20, 32'h40, 32'h9, 32'h77);
    slot_kind = {2'd0, 2'd2, 2'd3, 2'd0};
    slot_en = 4'b0011;
    resume_set = 1;
    tick();
    resume_set = 0; insn_start = 1; insn_addr = 16'h20;
    tick();
    check("R6 resume masks fetch", fault_req, 0);
    insn_start = 0; mem_valid = 1; mem_addr = 16'h40; mem_write = 0; insn_done = 1;
    tick();
    check("R7 resume does not mask data", trap_req, 1);
    check("R7 data hit_vec", hit_vec, 4'b0010);
    idle(); insn_start = 1; insn_addr = 16'h20;
    tick();
    check("R6 flag cleared after one insn", fault_req, 1);
    check("R6 hit_vec", hit_vec, 4'b0001);
    idle(); insn_done = 1; resume_set = 1;
    tick();
    idle(); insn_start = 1; insn_addr = 16'h20;
    tick();
    check("R6 set wins over done", fault_req, 0);
    idle(); insn_done = 1;
    tick();
    check("R6 no trap", trap_req, 0);
    idle(); insn_start = 1; insn_addr = 16'h20;
    tick();
    check("R6 fault after clear", fault_req, 1);
    idle();

    // Reset clears a set resume flag
    resume_set = 1;
    tick();
    idle(); rst_n = 0;
    tick();
    rst_n = 1;
    tick();
    insn_start = 1; insn_addr = 16'h20;
    tick();
    check("R1 reset clears resume", fault_req, 1);
    idle(); insn_done = 1;
    tick();
    idle();

    // Trap of one insn with fault of next in the same cycle
    insn_start = 1; insn_addr = 16'h10;
    tick();
    insn_start = 0; mem_valid = 1; mem_addr = 16'h40; mem_write = 1;
    tick();
    mem_valid = 0; insn_done = 1; insn_start = 1; insn_addr = 16'h20;
    tick();
    check("R11 both fault", fault_req, 1);
    check("R11 both trap", trap_req, 1);
    check("R11 union hit_vec", hit_vec, 4'b0011);
    idle(); insn_done = 1;
    tick();
    idle();

    // Repeated string data: slot1 rdwr 0x40, slot2 port 0x9
    slot_kind = {2'd0, 2'd2, 2'd3, 2'd0};
    slot_en = 4'b0110;
    str_rep = 1; insn_start = 1; insn_addr = 16'h100;
    tick();
    check("R3 disabled fetch slot", fault_req, 0);
    insn_start = 0; mem_valid = 1; mem_addr = 16'h3e; mem_write = 1; str_iter_done = 1;
    tick();
    check("R9 iter no match", trap_req, 0);
    mem_addr = 16'h40;
    tick();
    check("R9 trap after matching iteration", trap_req, 1);
    check("R9 hit_vec", hit_vec, 4'b0010);
    mem_addr = 16'h42;
    tick();
    check("R9 pending cleared", trap_req, 0);
    idle(); insn_done = 1;
    tick();
    check("R9 nothing left at done", trap_req, 0);
    idle();

    // Repeated port string: trap after first iteration
    insn_start = 1; insn_addr = 16'h100;
    tick();
    insn_start = 0; io_valid = 1; io_addr = 16'h9; str_iter_done = 1;
    tick();
    check("R9 port trap after first iter", trap_req, 1);
    check("R9 port hit_vec", hit_vec, 4'b0100);
    idle(); insn_done = 1;
    tick();
    check("R9 port done clean", trap_req, 0);
    idle(); str_rep = 0;

    // Iteration strobe without repeat is ignored
    insn_start = 1; insn_addr = 16'h100;
    tick();
    insn_start = 0; mem_valid = 1; mem_addr = 16'h40; mem_write = 0; str_iter_done = 1;
    tick();
    check("R10 iter ignored without rep", trap_req, 0);
    idle();
    tick();
    check("R10 still held", trap_req, 0);
    insn_done = 1;
    tick();
    check("R10/R5 reported at done", trap_req, 1);
    check("R10 hit_vec", hit_vec, 4'b0010);
    idle();
    tick();
    check("R11 idle hit_vec", hit_vec, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule